// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a register-access slave for a configuration port that uses three wires: a serial clock, an active-low select and one data line that both directions share. It links them to a small register file, one byte per address. The serial pins are brought into the system clock domain through a short synchronizer. The block then works on detected clock edges, so the whole design runs on one clock and has one asynchronous reset.

Each frame opens with a 16-bit instruction word. The word holds three fields:

- a direction flag;
- a length code, which selects one, two or three data bytes or an open-ended stream;
- a 13-bit start address.

Data bytes of 8 bits follow the instruction. On each new byte the address moves by one. It counts down when bits are sent most-significant first and counts up when they are sent least-significant first. On a read, the block takes over the data line once the instruction ends. It changes its output on falling serial edges. The host samples on rising edges. A host may raise the select at a byte boundary to pause a fixed-length frame. A bit in a configuration register chooses the bit order.

Top module: `spi3_reg_slave`

## Requirements
- R1: After reset, sdio_oe_o is 0, cfg_o is all zeros and bits travel MSB first.
- R2: A frame starts on the first rising sclk_i edge after csb_i goes low. sdio_i is sampled on rising edges. The first 16 bits form the instruction: bit 15 is the direction flag (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address. A write frame never drives the data line.
- R3: Length codes 00, 01 and 10 carry 1, 2 and 3 data bytes. After the last byte the frame is over: further sclk_i edges write nothing and do not drive the line until csb_i goes high and then low again.
- R4: Length code 11 streams bytes without limit until csb_i goes high. A rise of csb_i ends a streaming frame.
- R5: The address of each following byte is the previous address minus one in MSB-first order and plus one in LSB-first order, modulo 2^13.
- R6: On a read, sdio_oe_o goes high at the first falling sclk_i edge after the 16th rising edge, and that edge presents the first data bit. sdio_o changes only after falling edges.
- R7: sdio_oe_o is 0 whenever csb_i is high.
- R8: If csb_i goes high at a byte boundary of a fixed-length frame, or after 8 instruction bits, the frame is held. When csb_i returns low, the frame continues with the next bit.
- R9: If csb_i goes high in the middle of a byte, the frame is abandoned. A write byte that was not complete is discarded.
- R10: Address 0x000 bit 0 selects LSB-first order (1) for both instruction and data. The order is latched at the start of each frame, so a change applies from the next frame. This register reads back as {7'b0, bit}.
- R11: Address 0x001 reads back the constant chip ID 0x5A. Writes to it have no effect.
- R12: Addresses 0x010 to 0x013 are read/write bytes that appear on cfg_o, address 0x010+i at bits [8i+7:8i]. All other addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| csb_i | input | 1 | Select, active low |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Read data toward the pad |
| sdio_oe_o | output | 1 | Pad output enable |
| cfg_o | output | 32 | Contents of the read/write byte registers |

## Verification
The bench targets the read turnaround. A design that enables its output one edge late would return every read byte shifted by one bit. The bench also targets address stepping across the 13-bit wrap in both orders. A design that gets this wrong would return the wrong register on the second byte. Pauses at byte boundaries, aborts mid-byte and extra clocks after a fixed-length frame are each driven directly. A design that mishandles them either loses the rest of the frame, commits a partial byte, or writes a neighbouring register. A switch of bit order is exercised to show that it takes effect only from the next frame.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_DONE} frame_st_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csb_i,
  input  logic sdio_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_sel_o,
  output logic cs_rise_o,
  output logic sdio_o
);
  logic [STAGES-1:0] sclk_q, csb_q, sdio_q;
  logic sclk_d, csb_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      csb_q  <= '1;
      sdio_q <= '0;
      sclk_d <= 1'b0;
      csb_d  <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      csb_q  <= {csb_q[STAGES-2:0], csb_i};
      sdio_q <= {sdio_q[STAGES-2:0], sdio_i};
      sclk_d <= sclk_q[STAGES-1];
      csb_d  <= csb_q[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_sel_o    = ~csb_q[STAGES-1];
  assign cs_rise_o   = csb_q[STAGES-1] & ~csb_d;
  assign sdio_o      = sdio_q[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_sel_i,
  input  logic              cs_rise_i,
  input  logic              sdio_i,
  input  logic              cfg_lsb_i,
  input  logic [7:0]        rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wr_data_o,
  output logic              sdo_o,
  output logic              oe_o
);
  frame_st_e         state_q;
  logic [3:0]        cnt_q;
  logic [15:0]       sh_q, sh_nx;
  logic              lsb_q, rd_q, sdo_q, oe_q, ord;
  logic [1:0]        len_q, byte_q;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [2:0]        bit_idx;
  logic              last_byte, byte_end;
  instr_t            ins;

  // order is taken from the register only on the first bit of a frame
  assign ord       = (state_q == ST_IDLE) ? cfg_lsb_i : lsb_q;
  assign sh_nx     = ord ? {sdio_i, sh_q[15:1]} : {sh_q[14:0], sdio_i};
  assign ins       = instr_t'(sh_nx);
  assign addr_nx   = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
  assign bit_idx   = lsb_q ? cnt_q[2:0] : 3'd7 - cnt_q[2:0];
  assign last_byte = (len_q != LEN_STREAM) && (byte_q == len_q);
  assign byte_end  = (cnt_q[2:0] == 3'd7);

  assign wr_en_o   = sclk_rise_i && cs_sel_i && !cs_rise_i && (state_q == ST_DATA)
                     && !rd_q && byte_end;
  assign wr_data_o = lsb_q ? sh_nx[15:8] : sh_nx[7:0];
  assign addr_o    = addr_q;
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      lsb_q   <= 1'b0;
      rd_q    <= 1'b0;
      len_q   <= '0;
      byte_q  <= '0;
      addr_q  <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (state_q == ST_IDLE) oe_q <= 1'b0;
      if (cs_rise_i) begin
        unique case (state_q)
          ST_DONE:  state_q <= ST_IDLE;
          ST_INSTR: if (cnt_q[2:0] != 3'd0) state_q <= ST_IDLE;
          ST_DATA:  if (len_q == LEN_STREAM || cnt_q[2:0] != 3'd0) state_q <= ST_IDLE;
          default:  ;
        endcase
      end else if (sclk_rise_i && cs_sel_i) begin
        unique case (state_q)
          ST_IDLE: begin
            lsb_q   <= cfg_lsb_i;
            sh_q    <= sh_nx;
            cnt_q   <= 4'd1;
            state_q <= ST_INSTR;
          end
          ST_INSTR: begin
            sh_q <= sh_nx;
            if (cnt_q == 4'd15) begin
              rd_q    <= ins.rd;
              len_q   <= ins.len;
              addr_q  <= ins.addr;
              byte_q  <= '0;
              cnt_q   <= '0;
              state_q <= ST_DATA;
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_DATA: begin
            sh_q  <= sh_nx;
            cnt_q <= {1'b0, cnt_q[2:0] + 3'd1};
            if (byte_end) begin
              addr_q <= addr_nx;
              byte_q <= byte_q + 2'd1;
              if (last_byte) state_q <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
      if (sclk_fall_i && cs_sel_i) begin
        if (state_q == ST_DATA && rd_q) begin
          sdo_q <= rd_data_i[bit_idx];
          oe_q  <= 1'b1;
        end else begin
          oe_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile #(
  parameter int          ADDR_W    = 13,
  parameter int          NUM_USER  = 4,
  parameter int          USER_BASE = 16,
  parameter int          CFG_ADDR  = 0,
  parameter int          ID_ADDR   = 1,
  parameter logic [7:0]  CHIP_ID   = 8'h5A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [7:0]            rd_data_o,
  output logic                  lsb_first_o,
  output logic [NUM_USER*8-1:0] user_o
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] ID_A  = ADDR_W'(ID_ADDR);

  logic [7:0] user_q [NUM_USER];
  logic       lsb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             lsb_q <= 1'b0;
    else if (wr_en_i && addr_i == CFG_A)     lsb_q <= wr_data_i[0];
  end

  for (genvar g = 0; g < NUM_USER; g++) begin : g_user
    localparam logic [ADDR_W-1:0] UA = ADDR_W'(USER_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         user_q[g] <= '0;
      else if (wr_en_i && addr_i == UA)    user_q[g] <= wr_data_i;
    end
    assign user_o[g*8 +: 8] = user_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == CFG_A) rd_data_o = {7'b0, lsb_q};
    if (addr_i == ID_A)  rd_data_o = CHIP_ID;
    for (int i = 0; i < NUM_USER; i++)
      if (addr_i == ADDR_W'(USER_BASE + i)) rd_data_o = user_q[i];
  end

  assign lsb_first_o = lsb_q;
endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave
  import spi3_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_USER    = 4,
  parameter int         USER_BASE   = 16,
  parameter logic [7:0] CHIP_ID     = 8'h5A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  csb_i,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe_o,
  output logic [NUM_USER*8-1:0] cfg_o
);
  logic              sclk_rise, sclk_fall, cs_sel, cs_rise, sdio_s;
  logic              wr_en, lsb_first, oe_q;
  logic [ADDR_W-1:0] rw_addr;
  logic [7:0]        wr_data, rd_data;

  spi3_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .csb_i, .sdio_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_sel_o(cs_sel), .cs_rise_o(cs_rise), .sdio_o(sdio_s)
  );

  spi3_frame u_frame (
    .clk_i, .rst_ni,
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cs_sel_i(cs_sel), .cs_rise_i(cs_rise), .sdio_i(sdio_s),
    .cfg_lsb_i(lsb_first), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .addr_o(rw_addr), .wr_data_o(wr_data),
    .sdo_o(sdio_o), .oe_o(oe_q)
  );

  spi3_regfile #(
    .ADDR_W(ADDR_W), .NUM_USER(NUM_USER), .USER_BASE(USER_BASE), .CHIP_ID(CHIP_ID)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .addr_i(rw_addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .lsb_first_o(lsb_first), .user_o(cfg_o)
  );

  // pad driver follows the raw select so it releases without sync delay
  assign sdio_oe_o = oe_q & ~csb_i;
endmodule

// File: rtl/spi3_reg_slave_chk.sv
module spi3_reg_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csb_i,
  input logic              sdio_o,
  input logic              sdio_oe_o,
  input logic              sclk_fall,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rw_addr,
  input logic              lsb_first
);
  assert_oe_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> ($past(sclk_fall) || $fell(csb_i)));

  assert_sdo_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdio_o) |-> $past(sclk_fall));

  assert_no_drive_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !sdio_oe_o);

  assert_order_by_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lsb_first) |-> $past(wr_en && rw_addr == '0));
endmodule

bind spi3_reg_slave spi3_reg_slave_chk #(.ADDR_W(spi3_pkg::ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csb_i(csb_i), .sdio_o(sdio_o),
  .sdio_oe_o(sdio_oe_o), .sclk_fall(sclk_fall), .wr_en(wr_en),
  .rw_addr(rw_addr), .lsb_first(lsb_first)
);

// File: tb/spi3_reg_slave_tb.sv
module spi3_reg_slave_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, sdi = 1'b0;
  logic sdo, oe;
  logic [31:0] cfg;

  int n_tests = 0, n_fail = 0;
  logic [7:0]  m_user [4];
  logic        m_lsb;
  logic [7:0]  wbuf [8];
  logic [7:0]  rbuf [8];
  logic        last_oe;

  always #10 clk = ~clk;

  spi3_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_i(csb), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [12:0] a);
    if (a == 13'h000) return {7'b0, m_lsb};
    if (a == 13'h001) return 8'h5A;
    if (a >= 13'h010 && a <= 13'h013) return m_user[a - 13'h010];
    return 8'h00;
  endfunction

  function automatic void model_wr(input logic [12:0] a, input logic [7:0] d);
    if (a == 13'h000) m_lsb = d[0];
    if (a >= 13'h010 && a <= 13'h013) m_user[a - 13'h010] = d;
  endfunction

  function automatic logic [12:0] step(input logic [12:0] a, input logic lsb);
    return lsb ? a + 13'd1 : a - 13'd1;
  endfunction

  function automatic logic [31:0] model_cfg();
    return {m_user[3], m_user[2], m_user[1], m_user[0]};
  endfunction

  task automatic bit_cycle(input logic b, output logic r);
    @(negedge clk) sdi = b;
    repeat (H - 1) @(negedge clk);
    r = sdo;
    last_oe = oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk) csb = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk) csb = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic send_instr(input logic rd, input logic [1:0] len, input logic [12:0] a, input logic lsb);
    logic [15:0] w;
    logic r;
    w = {rd, len, a};
    for (int i = 0; i < 16; i++) bit_cycle(lsb ? w[i] : w[15 - i], r);
  endtask

  task automatic xfer_byte(input logic [7:0] wd, input logic lsb, output logic [7:0] rd, output logic oe0);
    logic r;
    rd = '0;
    oe0 = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(lsb ? wd[i] : wd[7 - i], r);
      if (i == 0) oe0 = last_oe;
      if (lsb) rd[i] = r; else rd[7 - i] = r;
    end
  endtask

  // whole frame against the model; reads check every byte, writes update the model
  task automatic do_frame(input logic rd, input logic [1:0] len, input logic [12:0] a0, input int nb, input string req);
    logic fl, oe0;
    logic [12:0] a;
    fl = m_lsb;
    a = a0;
    cs_low();
    send_instr(rd, len, a0, fl);
    for (int k = 0; k < nb; k++) begin
      xfer_byte(wbuf[k], fl, rbuf[k], oe0);
      if (rd) begin
        chk(rbuf[k] == model_rd(a), req, rbuf[k], model_rd(a));
        if (k == 0) chk(oe0 == 1'b1, "R6 oe at first bit", oe0, 1);
      end else begin
        model_wr(a, wbuf[k]);
      end
      a = step(a, fl);
    end
    cs_high();
    chk(oe == 1'b0, "R7 oe after frame", oe, 0);
    chk(cfg == model_cfg(), req, cfg, model_cfg());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic r, oe0;
    logic [7:0] b0;
    int seed;
    logic [12:0] pick [8];
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 4; i++) m_user[i] = '0;
    m_lsb = 1'b0;
    last_oe = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(oe == 1'b0, "R1 oe", oe, 0);
    chk(cfg == 32'h0, "R1 cfg", cfg, 0);

    // R2 R5 two-byte MSB write steps down
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    do_frame(1'b0, 2'b01, 13'h011, 2, "R2 R5 msb write");
    wbuf[0] = 8'hC3; wbuf[1] = 8'hD4;
    do_frame(1'b0, 2'b01, 13'h013, 2, "R2 write");

    // R4 streaming read of four bytes
    do_frame(1'b1, 2'b11, 13'h013, 4, "R4 R5 stream read");

    // R3 extra byte after fixed length must not write 0x012
    cs_low();
    send_instr(1'b0, 2'b00, 13'h013, 1'b0);
    xfer_byte(8'h3C, 1'b0, b0, oe0);
    model_wr(13'h013, 8'h3C);
    xfer_byte(8'hFF, 1'b0, b0, oe0);
    cs_high();
    chk(cfg == model_cfg(), "R3 extra clocks", cfg, model_cfg());

    // R3 oe released after fixed read ends, select still low
    cs_low();
    send_instr(1'b1, 2'b00, 13'h001, 1'b0);
    xfer_byte(8'h00, 1'b0, b0, oe0);
    chk(b0 == 8'h5A, "R11 chip id", b0, 8'h5A);
    bit_cycle(1'b0, r);
    bit_cycle(1'b0, r);
    chk(last_oe == 1'b0, "R3 no drive after end", last_oe, 0);
    cs_high();

    // R8 paused write
    cs_low();
    send_instr(1'b0, 2'b01, 13'h011, 1'b0);
    @(negedge clk) csb = 1'b1;
    repeat (4 * H) @(negedge clk);
    cs_low();
    xfer_byte(8'h66, 1'b0, b0, oe0);
    @(negedge clk) csb = 1'b1;
    repeat (4 * H) @(negedge clk);
    cs_low();
    xfer_byte(8'h77, 1'b0, b0, oe0);
    model_wr(13'h011, 8'h66);
    model_wr(13'h010, 8'h77);
    cs_high();
    chk(cfg == model_cfg(), "R8 paused write", cfg, model_cfg());

    // R8 R7 paused read
    cs_low();
    send_instr(1'b1, 2'b01, 13'h013, 1'b0);
    xfer_byte(8'h00, 1'b0, b0, oe0);
    chk(b0 == model_rd(13'h013), "R8 read byte0", b0, model_rd(13'h013));
    @(negedge clk) csb = 1'b1;
    repeat (4 * H) @(negedge clk);
    chk(oe == 1'b0, "R7 oe during pause", oe, 0);
    cs_low();
    xfer_byte(8'h00, 1'b0, b0, oe0);
    chk(b0 == model_rd(13'h012), "R8 read byte1", b0, model_rd(13'h012));
    cs_high();

    // R9 abort mid-byte discards partial write
    cs_low();
    send_instr(1'b0, 2'b00, 13'h010, 1'b0);
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, r);
    cs_high();
    chk(cfg == model_cfg(), "R9 abort", cfg, model_cfg());
    wbuf[0] = 8'h9E;
    do_frame(1'b0, 2'b00, 13'h010, 1, "R9 next frame");

    // R11 id write ignored, R12 unimplemented address
    wbuf[0] = 8'hFF;
    do_frame(1'b0, 2'b00, 13'h001, 1, "R11 id write");
    do_frame(1'b1, 2'b00, 13'h001, 1, "R11 id read");
    do_frame(1'b0, 2'b00, 13'h005, 1, "R12 unimpl write");
    do_frame(1'b1, 2'b00, 13'h005, 1, "R12 unimpl read");

    // R5 msb decrement wraps below zero
    do_frame(1'b1, 2'b01, 13'h000, 2, "R5 msb wrap");

    // R10 switch to LSB first; takes effect next frame
    wbuf[0] = 8'h01;
    do_frame(1'b0, 2'b00, 13'h000, 1, "R10 set lsb");
    do_frame(1'b1, 2'b00, 13'h000, 1, "R10 lsb readback");
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    do_frame(1'b0, 2'b10, 13'h011, 3, "R10 R5 lsb write up");
    do_frame(1'b1, 2'b01, 13'h1FFF, 2, "R5 lsb wrap");

    // constrained random frames
    pick[0] = 13'h010; pick[1] = 13'h011; pick[2] = 13'h012; pick[3] = 13'h013;
    pick[4] = 13'h001; pick[5] = 13'h000; pick[6] = 13'h1FFF; pick[7] = 13'h007;
    for (int n = 0; n < 40; n++) begin
      logic rdr;
      logic [1:0] ln;
      int nb;
      rdr = 1'($urandom % 2);
      ln = 2'($urandom % 4);
      nb = (ln == 2'b11) ? 1 + int'($urandom % 4) : int'(ln) + 1;
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      do_frame(rdr, ln, pick[$urandom % 8], nb, rdr ? "R2 R12 random read" : "R12 random write");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule